// File: doc/BRIEF.md
# Eight-Word Instruction Loop Buffer

This block sits between instruction memory and an issue stage. It remembers the last eight 60-bit instruction words it pulled from memory, each tagged with its word address. When the program jumps to a word it already holds, the word is taken from the buffer and no memory request is made. When the target is not held, one fetch goes out at the target address and the parcel output stays idle until that word comes back. Sequential flow uses the same lookup, so a short loop closed by a conditional jump runs from the buffer after its first pass.

Each current word is cut into instruction parcels for the issue stage, starting from the most significant end. A parcel is 15 bits, or 30 bits when it is marked long. For long parcels, an 18-bit jump address field is exposed as well. A redirect carries a target word address and a flag giving its kind. A conditional redirect keeps the buffer contents. An unconditional redirect empties the buffer first. Evaluating branch conditions and executing instructions happen elsewhere.

Top module: `iword_loop_buf`

## Requirements
- R1: After reset, no parcel is valid, the buffer holds nothing, and the first fetch request is for word address 0.
- R2: If the wanted word address is held, the word is loaded from the buffer with no fetch request. Its first parcel is valid on the second clock after a redirect.
- R3: An unconditional redirect (`redir_uncond`=1) invalidates every entry, so the target and later words are fetched from memory even if they were held before.
- R4: The buffer keeps the eight most recently fetched words. A ninth fetched word evicts the oldest of them, in first-in first-out order.
- R5: On a miss, a fetch request is raised at the wanted word address, and `par_valid` stays 0 until the response arrives. At most one request is outstanding at a time. A response to a request made before a redirect, or arriving in the cycle of a redirect, is dropped.
- R6: Parcel slot k (k=0..3) of a word is bits [59-15k : 45-15k]. Slot 0 is delivered first, and a word entered through a redirect starts at slot 0. While `par_valid`=1 and `par_ready`=0, the output holds steady.
- R7: A parcel is long when its slot's most significant bit is 1 and the slot is 0, 1 or 2. A long parcel takes two slots and is presented whole on `par_data`. A short parcel is right-aligned on `par_data` with the upper 15 bits zero. Slot 3 is always short, since a parcel never spans two words.
- R8: `par_jaddr` equals the low 18 bits of a long parcel and is 0 for a short parcel.
- R9: After the last parcel of a word is accepted, the next wanted word address is the current one plus 1, wrapping at 2^18.
- R10: A redirect takes priority over parcel acceptance and over a fetch response in the same cycle. `par_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req_valid | output | 1 | Fetch request valid |
| fetch_req_ready | input | 1 | Memory accepts the request |
| fetch_req_addr | output | 18 | Word address to fetch |
| fetch_rsp_valid | input | 1 | Fetched word present |
| fetch_rsp_data | input | 60 | Fetched instruction word |
| redir_valid | input | 1 | Jump redirect |
| redir_uncond | input | 1 | 1 = unconditional jump (flushes buffer) |
| redir_target | input | 18 | Jump target word address |
| par_valid | output | 1 | Parcel valid |
| par_ready | input | 1 | Issue stage takes the parcel |
| par_data | output | 30 | Parcel bits (short parcels right-aligned) |
| par_long | output | 1 | Parcel is 30 bits |
| par_jaddr | output | 18 | Address field of a long parcel, else 0 |
| par_waddr | output | 18 | Word address of the current parcel |
| par_slot | output | 2 | Slot index of the parcel in its word |

## Verification
The assertions assume that memory returns exactly one response for each accepted request, and only while that request is outstanding. They do not assume any particular latency. The bench memory follows this rule: it answers every accepted address once, after one to four cycles, and it accepts nothing while an answer is pending. Redirects are injected at random, including in cycles where a response is arriving or a request is being accepted. Targets are mostly a few words behind the current address, which causes both hits and evictions, and some targets sit near the top of the address space to exercise the wrap.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  parameter int unsigned LB_WORD_W   = 60;
  parameter int unsigned LB_ADDR_W   = 18;
  parameter int unsigned LB_PARCEL_W = 15;
  parameter int unsigned LB_JADDR_W  = 18;
  parameter int unsigned LB_DEPTH    = 8;

  localparam int unsigned LB_SLOTS  = LB_WORD_W / LB_PARCEL_W;
  localparam int unsigned LB_SLOT_W = $clog2(LB_SLOTS);
  localparam int unsigned LB_LONG_W = 2 * LB_PARCEL_W;

  typedef logic [LB_WORD_W-1:0] word_t;
  typedef logic [LB_ADDR_W-1:0] waddr_t;
  typedef logic [LB_LONG_W-1:0] parcel_t;
endpackage

// File: rtl/lbuf_store.sv
module lbuf_store
  import lbuf_pkg::*;
#(
  parameter int unsigned DEPTH = LB_DEPTH
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  logic   wr_en,
  input  waddr_t wr_addr,
  input  word_t  wr_data,
  input  waddr_t rd_addr,
  output logic   hit,
  output word_t  hit_data
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] match;
  logic [IDX_W-1:0] wp_q, wp_d;
  waddr_t           tag_q [DEPTH];
  word_t            dat_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign match[i] = vld_q[i] && (tag_q[i] == rd_addr);

    always_ff @(posedge clk) begin
      if (wr_en && !flush && (wp_q == IDX_W'(i))) begin
        tag_q[i] <= wr_addr;
        dat_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    wp_d  = wp_q;
    if (flush) begin
      vld_d = '0;
      wp_d  = '0;
    end else if (wr_en) begin
      vld_d[wp_q] = 1'b1;
      wp_d = (wp_q == IDX_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      wp_q  <= wp_d;
    end
  end

  assign hit = |match;

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_data = hit_data | dat_q[i];
    end
  end

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R3
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0) && !hit);

  // R4
  fill_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $countones(vld_q) >= $past($countones(vld_q)));
endmodule

// File: rtl/lbuf_fetch.sv
module lbuf_fetch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic rsp_valid,
  input  logic redirect,
  output logic outst,
  output logic rsp_keep
);
  logic out_q, out_d;
  logic disc_q, disc_d;

  always_comb begin
    out_d  = out_q;
    disc_d = disc_q;
    if (redirect) begin
      out_d  = (out_q && !rsp_valid) || req_fire;
      disc_d = out_d;
    end else begin
      if (rsp_valid) begin
        out_d  = 1'b0;
        disc_d = 1'b0;
      end
      if (req_fire) begin
        out_d  = 1'b1;
        disc_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      disc_q <= disc_d;
    end
  end

  assign outst    = out_q;
  assign rsp_keep = rsp_valid && out_q && !disc_q && !redirect;

  // R5
  rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> out_q);

  // R5
  stale_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && out_q && !rsp_valid) |=> outst && !rsp_keep);
endmodule

// File: rtl/lbuf_parcel.sv
module lbuf_parcel
  import lbuf_pkg::*;
(
  input  word_t                word_i,
  input  logic [LB_SLOT_W-1:0] slot_i,
  output parcel_t              data_o,
  output logic                 long_o,
  output logic [LB_JADDR_W-1:0] jaddr_o
);
  word_t   shifted;
  parcel_t head;

  always_comb begin
    shifted = word_i << (slot_i * LB_PARCEL_W);
    head    = shifted[LB_WORD_W-1 -: LB_LONG_W];
    long_o  = head[LB_LONG_W-1] && (slot_i != LB_SLOT_W'(LB_SLOTS - 1));
    data_o  = long_o ? head : {{LB_PARCEL_W{1'b0}}, head[LB_LONG_W-1:LB_PARCEL_W]};
    jaddr_o = long_o ? head[LB_JADDR_W-1:0] : '0;
  end
endmodule

// File: rtl/iword_loop_buf.sv
module iword_loop_buf
  import lbuf_pkg::*;
#(
  parameter int unsigned DEPTH = LB_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  fetch_req_valid,
  input  logic                  fetch_req_ready,
  output logic [LB_ADDR_W-1:0]  fetch_req_addr,
  input  logic                  fetch_rsp_valid,
  input  logic [LB_WORD_W-1:0]  fetch_rsp_data,
  input  logic                  redir_valid,
  input  logic                  redir_uncond,
  input  logic [LB_ADDR_W-1:0]  redir_target,
  output logic                  par_valid,
  input  logic                  par_ready,
  output logic [LB_LONG_W-1:0]  par_data,
  output logic                  par_long,
  output logic [LB_JADDR_W-1:0] par_jaddr,
  output logic [LB_ADDR_W-1:0]  par_waddr,
  output logic [LB_SLOT_W-1:0]  par_slot
);
  logic [1:0] rs_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  logic                 cur_v_q, cur_v_d;
  word_t                word_q, word_d;
  logic                 word_en;
  waddr_t               pc_q, pc_d;
  logic [LB_SLOT_W-1:0] slot_q, slot_d;
  logic [LB_SLOT_W:0]   slot_sum;
  logic                 last;

  logic   st_hit, outst, rsp_keep, req_fire, flush;
  word_t  st_data;
  logic   p_long;

  assign flush           = redir_valid && redir_uncond;
  assign fetch_req_valid = !cur_v_q && !st_hit && !outst;
  assign fetch_req_addr  = pc_q;
  assign req_fire        = fetch_req_valid && fetch_req_ready;

  lbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_int),
    .flush    (flush),
    .wr_en    (rsp_keep),
    .wr_addr  (pc_q),
    .wr_data  (fetch_rsp_data),
    .rd_addr  (pc_q),
    .hit      (st_hit),
    .hit_data (st_data)
  );

  lbuf_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_int),
    .req_fire  (req_fire),
    .rsp_valid (fetch_rsp_valid),
    .redirect  (redir_valid),
    .outst     (outst),
    .rsp_keep  (rsp_keep)
  );

  lbuf_parcel u_parcel (
    .word_i  (word_q),
    .slot_i  (slot_q),
    .data_o  (par_data),
    .long_o  (p_long),
    .jaddr_o (par_jaddr)
  );

  assign slot_sum = {1'b0, slot_q} + (p_long ? (LB_SLOT_W+1)'(2) : (LB_SLOT_W+1)'(1));
  assign last     = (slot_sum >= (LB_SLOT_W+1)'(LB_SLOTS));
  assign word_en  = !redir_valid && (rsp_keep || (!cur_v_q && st_hit));

  always_comb begin
    cur_v_d = cur_v_q;
    pc_d    = pc_q;
    slot_d  = slot_q;
    word_d  = rsp_keep ? fetch_rsp_data : st_data;
    if (redir_valid) begin
      cur_v_d = 1'b0;
      pc_d    = redir_target;
      slot_d  = '0;
    end else if (rsp_keep || (!cur_v_q && st_hit)) begin
      cur_v_d = 1'b1;
      slot_d  = '0;
    end else if (cur_v_q && par_ready) begin
      if (last) begin
        cur_v_d = 1'b0;
        pc_d    = pc_q + 1'b1;
        slot_d  = '0;
      end else begin
        slot_d  = slot_sum[LB_SLOT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      cur_v_q <= 1'b0;
      pc_q    <= '0;
      slot_q  <= '0;
    end else begin
      cur_v_q <= cur_v_d;
      pc_q    <= pc_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk) begin
    if (word_en) word_q <= word_d;
  end

  assign par_valid = cur_v_q;
  assign par_long  = p_long;
  assign par_waddr = pc_q;
  assign par_slot  = slot_q;

  // R2
  hit_load_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (!cur_v_q && st_hit && !redir_valid) |=> par_valid);

  // R10
  redir_drop_chk: assert property (@(posedge clk) disable iff (!rst_int)
    redir_valid |=> !par_valid && (par_slot == '0));

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (par_valid && !par_ready && !redir_valid) |=>
      par_valid && $stable(par_data) && $stable(par_waddr));

  // R9
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_int)
    (par_valid && par_ready && !redir_valid && last) |=>
      (par_waddr == $past(par_waddr) + 1'b1) && !par_valid);
endmodule

// File: tb/iword_loop_buf_tb_top.sv
module iword_loop_buf_tb_top;
  import lbuf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req_valid, fetch_req_ready;
  logic [17:0] fetch_req_addr;
  logic        fetch_rsp_valid;
  logic [59:0] fetch_rsp_data;
  logic        redir_valid, redir_uncond;
  logic [17:0] redir_target;
  logic        par_valid, par_ready, par_long;
  logic [29:0] par_data;
  logic [17:0] par_jaddr, par_waddr;
  logic [1:0]  par_slot;

  always #5 clk = ~clk;

  iword_loop_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_req_addr(fetch_req_addr),
    .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
    .redir_valid(redir_valid), .redir_uncond(redir_uncond), .redir_target(redir_target),
    .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
    .par_long(par_long), .par_jaddr(par_jaddr), .par_waddr(par_waddr),
    .par_slot(par_slot)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [59:0] mem_word(input logic [17:0] a);
    logic [63:0] h;
    h = {14'd0, a, 14'd0, a} * 64'h9E37_79B9_7F4A_7C15;
    return h[63:4] ^ {42'd0, a};
  endfunction

  // reference model state
  bit          m_cv, m_out, m_disc;
  logic [59:0] m_word;
  logic [17:0] m_pc;
  int          m_slot;
  logic [17:0] qa[$];
  logic [59:0] qd[$];
  // memory model state
  bit          mem_busy;
  int          mem_cnt;
  logic [17:0] mem_addr;
  // per-cycle scratch
  int          hidx, nslot, r;
  bit          e_req, e_lg, fire, acc;
  logic [14:0] e_p;
  logic [29:0] e_data;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_req_ready = 1'b0; fetch_rsp_valid = 1'b0; fetch_rsp_data = '0;
    redir_valid = 1'b0; redir_uncond = 1'b0; redir_target = '0; par_ready = 1'b0;
    m_cv = 0; m_out = 0; m_disc = 0; m_word = '0; m_pc = '0; m_slot = 0;
    mem_busy = 0; mem_cnt = 0; mem_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      // expected outputs from model state
      hidx = -1;
      if (!m_cv) for (int i = 0; i < qa.size(); i++) if (qa[i] == m_pc) hidx = i;
      e_req = !m_cv && (hidx < 0) && !m_out;
      if (cyc == 0) begin
        chk("R1 par_valid after reset", {63'd0, par_valid}, 64'd0);
        chk("R1 first fetch valid", {63'd0, fetch_req_valid}, 64'd1);
        chk("R1 first fetch address", {46'd0, fetch_req_addr}, 64'd0);
      end
      chk("R2 R3 R4 R5 fetch_req_valid", {63'd0, fetch_req_valid}, {63'd0, e_req});
      if (e_req) chk("R5 R9 fetch_req_addr", {46'd0, fetch_req_addr}, {46'd0, m_pc});
      chk("R5 R10 par_valid", {63'd0, par_valid}, {63'd0, m_cv});
      e_lg = 0;
      if (m_cv) begin
        e_p    = 15'((m_word >> (15 * (3 - m_slot))) & 60'h7FFF);
        e_lg   = (m_slot < 3) && e_p[14];
        e_data = e_lg ? 30'((m_word >> (15 * (2 - m_slot))) & 60'h3FFF_FFFF) : {15'd0, e_p};
        chk("R6 R7 par_data", {34'd0, par_data}, {34'd0, e_data});
        chk("R7 par_long", {63'd0, par_long}, {63'd0, e_lg});
        chk("R8 par_jaddr", {46'd0, par_jaddr}, e_lg ? {46'd0, e_data[17:0]} : 64'd0);
        chk("R9 par_waddr", {46'd0, par_waddr}, {46'd0, m_pc});
        chk("R6 par_slot", {62'd0, par_slot}, 64'(m_slot));
      end

      // drive inputs for this cycle
      par_ready       = ($urandom_range(0, 3) != 0);
      fetch_req_ready = ($urandom_range(0, 3) != 0);
      fetch_rsp_valid = 1'b0;
      if (mem_busy && mem_cnt == 0) begin
        fetch_rsp_valid = 1'b1;
        fetch_rsp_data  = mem_word(mem_addr);
      end
      redir_valid  = ($urandom_range(0, 13) == 0);
      redir_uncond = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 9);
      if (r < 6)       redir_target = m_pc - 18'(r);
      else if (r == 6) redir_target = 18'h3FFFE;
      else             redir_target = 18'($urandom_range(0, 40));

      // memory model
      fire = e_req && fetch_req_ready;
      if (fetch_rsp_valid) mem_busy = 0;
      else if (mem_busy) mem_cnt--;
      if (fire) begin
        mem_busy = 1; mem_cnt = $urandom_range(0, 3); mem_addr = m_pc;
      end

      // reference model next state
      if (redir_valid) begin
        if (redir_uncond) begin qa.delete(); qd.delete(); end
        m_out  = (m_out && !fetch_rsp_valid) || fire;
        m_disc = m_out;
        m_cv   = 0; m_pc = redir_target; m_slot = 0;
      end else begin
        acc = m_cv && par_ready;
        if (fetch_rsp_valid) begin
          if (!m_disc) begin
            if (qa.size() == 8) begin void'(qa.pop_front()); void'(qd.pop_front()); end
            qa.push_back(m_pc); qd.push_back(fetch_rsp_data);
            m_cv = 1; m_word = fetch_rsp_data; m_slot = 0;
          end
          m_out = 0; m_disc = 0;
        end
        if (fire) begin m_out = 1; m_disc = 0; end
        if (hidx >= 0) begin
          m_cv = 1; m_word = qd[hidx]; m_slot = 0;
        end else if (acc) begin
          nslot = m_slot + (e_lg ? 2 : 1);
          if (nslot >= 4) begin m_cv = 0; m_pc = m_pc + 18'd1; m_slot = 0; end
          else m_slot = nslot;
        end
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule